// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block follows a chain of descriptors in memory and hands the payload words of each descriptor, in order, to a peripheral sink. Each descriptor starts with one header word. The top 8 bits of the header give the number of payload words. The low 24 bits point to the next descriptor. The payload words sit directly after the header. A next pointer of all ones (0xFFFFFF) ends the chain. Only the memory-to-device direction is handled.

Software loads a start address with a start strobe. The busy flag then stays high until the chain ends or a bus error stops the walk. The walk advances only while the device holds its request. It also charges the cycles it spends against a programmable budget. At a descriptor boundary, the walker yields if the request has dropped or the budget is used up. It stores its resume address in the readable base register. If it yielded on budget with the request still high, it waits a fixed hold-off before it retries. A header fetch that would run past the end of memory raises a bus-error pulse instead. The completion and bus-error pulses feed an interrupt block outside this one.

Top module: `ldw_walker`

## Requirements
- R1: After reset, busy, doneIrq, busErr, memRdEn and sinkValid are 0 and baseAddr is 0.
- R2: A start strobe while idle loads baseAddr with startAddr and raises busy on the next edge. A start strobe while busy is ignored: the base value does not change, the chain in progress goes on, and the new address is never walked.
- R3: A header word holds the payload word count in bits 31:24 and the next pointer in bits 23:0. The payload words are read from header+4 upward in steps of 4 bytes. They are presented on the sink in that order, and each word is held stable while sinkReady is low.
- R4: Every memory read address is the 24-bit address with its two low bits cleared. This applies to the start address, to next pointers and to payload addresses.
- R5: When a descriptor's next pointer equals 0xFFFFFF, the walker sets baseAddr to 0xFFFFFF and clears busy once that descriptor finishes. It also raises doneIrq for one cycle on the same edge.
- R6: With the request high and the sink always ready, each descriptor costs 1 boundary cycle and 10 header cycles. A nonzero-length descriptor adds 5 setup cycles plus 2 cycles per word. The done pulse is visible after edge 1+Σcost, where edge 0 is the edge that takes the start strobe.
- R7: Header, setup and payload cycles are charged to the current slice. At a descriptor boundary where the charge is at least the budget, the walker yields. A descriptor that has begun always finishes first. baseAddr then shows the next descriptor address and busy stays 1. The walk later completes with the full word stream.
- R8: At a descriptor boundary with devReq low, the walker parks. baseAddr holds the next descriptor address, and no memory reads or sink words occur. When devReq returns high, the walk resumes from that address.
- R9: After a budget yield with devReq high, the next header read comes HOLDOFF+1 cycles after baseAddr changes. HOLDOFF defaults to 100.
- R10: If the aligned header address plus 4 exceeds the 8 MiB memory size, no read is issued. busErr pulses for one cycle, busy clears, baseAddr takes that descriptor address, and doneIrq stays low.
- R11: While busy is 0, memRdEn and sinkValid stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startWr | input | 1 | Start strobe, one cycle |
| startAddr | input | 24 | Address of the first descriptor, taken with startWr |
| devReq | input | 1 | Device request; the walk advances only while high |
| budget | input | 16 | Cycle budget for each slice (1000 is the usual value) |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | 24 | Word-aligned byte address of the read |
| memRdData | input | 32 | Read data, valid the cycle after memRdEn and held until the next read |
| sinkValid | output | 1 | Payload word valid |
| sinkData | output | 32 | Payload word |
| sinkReady | input | 1 | Sink accepts the word on this edge |
| busy | output | 1 | Start/busy status |
| baseAddr | output | 24 | Base/resume address register |
| doneIrq | output | 1 | Chain-complete pulse |
| busErr | output | 1 | Bus-error pulse |

## Verification
Both event pulses are registered on the edge that decides the event. A bus error appears after the boundary edge. The done pulse appears after edge 1+Σcost counted from the start edge, so the bench counts falling edges from the start strobe and compares the exact count with a cost function. After a budget yield, the base register changes on the yield edge, and the next header read strobe is expected exactly HOLDOFF+1 cycles later. Every sample is taken 2 ns after a falling edge. The sink monitor records a word only when valid and ready are both high at the falling edge before the accepting rising edge.

// File: rtl/ldw_pkg.sv
package ldw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PARK,
    S_HOLD,
    S_CHECK,
    S_HDR,
    S_SETUP,
    S_FETCH,
    S_SEND
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic saveBase;
    logic saveTerm;
    logic clearUsed;
    logic charge;
    logic hdrRead;
    logic capHdr;
    logic startPayload;
    logic wordRead;
    logic wordDone;
    logic advance;
  } walkCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic spent;
    logic fault;
    logic lenZero;
    logic lastWord;
    logic nextIsTerm;
  } walkStat_t;

endpackage

// File: rtl/ldw_datapath.sv
module ldw_datapath
  import ldw_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DATA_W    = 32,
  parameter int          LEN_W     = 8,
  parameter int          BUDGET_W  = 16,
  parameter int unsigned MEM_BYTES = 32'd8388608
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkCtl_t            ctl,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [BUDGET_W-1:0] budget,
  input  logic [DATA_W-1:0]   memRdData,
  output logic [ADDR_W-1:0]   memRdAddr,
  output logic [ADDR_W-1:0]   baseAddr,
  output walkStat_t           st
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};
  localparam logic [ADDR_W-1:0] END_PTR    = '1;
  localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(4);
  localparam logic [ADDR_W:0]   MEM_LIMIT  = (ADDR_W+1)'(MEM_BYTES);

  logic [ADDR_W-1:0]   curAddr, baseReg, hdrNext, wordAddr;
  logic [LEN_W-1:0]    hdrCount, remain;
  logic [BUDGET_W-1:0] used;
  logic [ADDR_W-1:0]   curAligned;
  logic [ADDR_W:0]     fetchEnd;

  assign curAligned = curAddr & ALIGN_MASK;
  assign fetchEnd   = {1'b0, curAligned} + (ADDR_W+1)'(4);
  assign memRdAddr  = ctl.wordRead ? wordAddr : curAligned;
  assign baseAddr   = baseReg;

  assign st.spent      = (used >= budget);
  assign st.fault      = (fetchEnd > MEM_LIMIT);
  assign st.lenZero    = (hdrCount == '0);
  assign st.lastWord   = (remain == LEN_W'(1));
  assign st.nextIsTerm = (hdrNext == END_PTR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      baseReg  <= '0;
      hdrNext  <= '0;
      hdrCount <= '0;
      wordAddr <= '0;
      remain   <= '0;
      used     <= '0;
    end else begin
      if (ctl.loadStart) begin
        curAddr <= startAddr;
        baseReg <= startAddr;
      end
      if (ctl.saveBase) baseReg <= curAddr;
      if (ctl.saveTerm) baseReg <= END_PTR;
      if (ctl.capHdr) begin
        hdrCount <= memRdData[DATA_W-1 -: LEN_W];
        hdrNext  <= memRdData[ADDR_W-1:0];
      end
      if (ctl.startPayload) begin
        wordAddr <= (curAligned + WORD_STEP) & ALIGN_MASK;
        remain   <= hdrCount;
      end
      if (ctl.wordDone) begin
        wordAddr <= (wordAddr + WORD_STEP) & ALIGN_MASK;
        remain   <= remain - LEN_W'(1);
      end
      if (ctl.advance) curAddr <= hdrNext;
      if (ctl.clearUsed)                  used <= '0;
      else if (ctl.charge && used != '1) used <= used + BUDGET_W'(1);
    end
  end

endmodule

// File: rtl/ldw_control.sv
module ldw_control
  import ldw_pkg::*;
#(
  parameter int HDR_CYC   = 10,
  parameter int SETUP_CYC = 5,
  parameter int HOLDOFF   = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startWr,
  input  logic      devReq,
  input  logic      sinkReady,
  input  walkStat_t st,
  output walkCtl_t  ctl,
  output logic      memRdEn,
  output logic      sinkValid,
  output logic      busy,
  output logic      doneIrq,
  output logic      busErr
);
  localparam int PH_MAX0 = (HDR_CYC > SETUP_CYC) ? HDR_CYC : SETUP_CYC;
  localparam int PH_MAX  = (HOLDOFF > PH_MAX0) ? HOLDOFF : PH_MAX0;
  localparam int PH_W    = $clog2(PH_MAX + 1);

  walkState_e      state, stateNx;
  logic [PH_W-1:0] phase, phaseNx;
  logic            doneNx, errNx;

  assign busy      = (state != S_IDLE);
  assign sinkValid = (state == S_SEND);
  assign memRdEn   = ctl.hdrRead | ctl.wordRead;

  always_comb begin
    ctl     = '0;
    stateNx = state;
    phaseNx = phase;
    doneNx  = 1'b0;
    errNx   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startWr) begin
          ctl.loadStart = 1'b1;
          stateNx       = S_PARK;
        end
      end
      S_PARK: begin
        if (devReq) begin
          ctl.clearUsed = 1'b1;
          stateNx       = S_CHECK;
        end
      end
      S_HOLD: begin
        if (phase == '0) begin
          ctl.clearUsed = 1'b1;
          stateNx       = S_CHECK;
        end else begin
          phaseNx = phase - PH_W'(1);
        end
      end
      S_CHECK: begin
        if (!devReq) begin
          ctl.saveBase = 1'b1;
          stateNx      = S_PARK;
        end else if (st.spent) begin
          ctl.saveBase = 1'b1;
          stateNx      = S_HOLD;
          phaseNx      = PH_W'(HOLDOFF - 1);
        end else if (st.fault) begin
          ctl.saveBase = 1'b1;
          errNx        = 1'b1;
          stateNx      = S_IDLE;
        end else begin
          stateNx = S_HDR;
          phaseNx = PH_W'(HDR_CYC - 1);
        end
      end
      S_HDR: begin
        ctl.charge  = 1'b1;
        ctl.hdrRead = (phase == PH_W'(HDR_CYC - 1));
        ctl.capHdr  = (phase == PH_W'(HDR_CYC - 2));
        if (phase != '0) begin
          phaseNx = phase - PH_W'(1);
        end else if (!st.lenZero) begin
          stateNx = S_SETUP;
          phaseNx = PH_W'(SETUP_CYC - 1);
        end else begin
          ctl.advance = 1'b1;
          if (st.nextIsTerm) begin
            ctl.saveTerm = 1'b1;
            doneNx       = 1'b1;
            stateNx      = S_IDLE;
          end else begin
            stateNx = S_CHECK;
          end
        end
      end
      S_SETUP: begin
        ctl.charge = 1'b1;
        if (phase == '0) begin
          ctl.startPayload = 1'b1;
          stateNx          = S_FETCH;
        end else begin
          phaseNx = phase - PH_W'(1);
        end
      end
      S_FETCH: begin
        ctl.charge   = 1'b1;
        ctl.wordRead = 1'b1;
        stateNx      = S_SEND;
      end
      S_SEND: begin
        ctl.charge = 1'b1;
        if (sinkReady) begin
          ctl.wordDone = 1'b1;
          if (!st.lastWord) begin
            stateNx = S_FETCH;
          end else begin
            ctl.advance = 1'b1;
            if (st.nextIsTerm) begin
              ctl.saveTerm = 1'b1;
              doneNx       = 1'b1;
              stateNx      = S_IDLE;
            end else begin
              stateNx = S_CHECK;
            end
          end
        end
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= '0;
      doneIrq <= 1'b0;
      busErr  <= 1'b0;
    end else begin
      state   <= stateNx;
      phase   <= phaseNx;
      doneIrq <= doneNx;
      busErr  <= errNx;
    end
  end

endmodule

// File: rtl/ldw_walker.sv
module ldw_walker
  import ldw_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DATA_W    = 32,
  parameter int          LEN_W     = 8,
  parameter int          BUDGET_W  = 16,
  parameter int          HDR_CYC   = 10,
  parameter int          SETUP_CYC = 5,
  parameter int          HOLDOFF   = 100,
  parameter int unsigned MEM_BYTES = 32'd8388608
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startWr,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic                devReq,
  input  logic [BUDGET_W-1:0] budget,
  output logic                memRdEn,
  output logic [ADDR_W-1:0]   memRdAddr,
  input  logic [DATA_W-1:0]   memRdData,
  output logic                sinkValid,
  output logic [DATA_W-1:0]   sinkData,
  input  logic                sinkReady,
  output logic                busy,
  output logic [ADDR_W-1:0]   baseAddr,
  output logic                doneIrq,
  output logic                busErr
);
  walkCtl_t  ctl;
  walkStat_t st;

  // memory holds read data until the next read, so the sink sees it directly
  assign sinkData = memRdData;

  ldw_control #(
    .HDR_CYC(HDR_CYC), .SETUP_CYC(SETUP_CYC), .HOLDOFF(HOLDOFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .devReq(devReq),
    .sinkReady(sinkReady), .st(st), .ctl(ctl), .memRdEn(memRdEn),
    .sinkValid(sinkValid), .busy(busy), .doneIrq(doneIrq), .busErr(busErr)
  );

  ldw_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .BUDGET_W(BUDGET_W), .MEM_BYTES(MEM_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .budget(budget), .memRdData(memRdData), .memRdAddr(memRdAddr),
    .baseAddr(baseAddr), .st(st)
  );

endmodule

// File: rtl/ldw_walker_chk.sv
module ldw_walker_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startWr,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              sinkValid,
  input logic              sinkReady,
  input logic [DATA_W-1:0] sinkData,
  input logic              busy,
  input logic [ADDR_W-1:0] baseAddr,
  input logic              doneIrq,
  input logic              busErr
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdEn && !sinkValid));

  // R3
  sink_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinkValid && !sinkReady) |=> (sinkValid && $stable(sinkData)));

  // R5
  done_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!busy && baseAddr == {ADDR_W{1'b1}}));

  // R10
  err_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (!busy && !doneIrq));

  // R4
  read_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memRdAddr[1:0] == 2'b00));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startWr));

endmodule

bind ldw_walker ldw_walker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .startWr(startWr), .memRdEn(memRdEn),
  .memRdAddr(memRdAddr), .sinkValid(sinkValid), .sinkReady(sinkReady),
  .sinkData(sinkData), .busy(busy), .baseAddr(baseAddr),
  .doneIrq(doneIrq), .busErr(busErr)
);

// File: tb/tb_ldw_walker.sv
`timescale 1ns/1ps
module tb_ldw_walker;
  localparam int HOLD = 100;
  localparam logic [23:0] TERM = 24'hFFFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startWr = 1'b0;
  logic [23:0] startAddr = '0;
  logic        devReq = 1'b1;
  logic [15:0] budget = 16'd1000;
  logic        memRdEn;
  logic [23:0] memRdAddr;
  logic [31:0] memRdData = '0;
  logic        sinkValid;
  logic [31:0] sinkData;
  logic        sinkReady = 1'b1;
  logic        busy;
  logic [23:0] baseAddr;
  logic        doneIrq;
  logic        busErr;

  ldw_walker dut (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startAddr(startAddr),
    .devReq(devReq), .budget(budget), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .sinkValid(sinkValid), .sinkData(sinkData),
    .sinkReady(sinkReady), .busy(busy), .baseAddr(baseAddr),
    .doneIrq(doneIrq), .busErr(busErr)
  );

  always #10 clk = ~clk;

  logic [31:0] mem [0:4095];
  always @(posedge clk) if (memRdEn) memRdData <= mem[memRdAddr[13:2]];

  int checks = 0, failures = 0, cyc = 0;
  int gotN = 0, expN = 0, rdCount = 0, expCost = 0;
  bit randReady = 1'b0, expErr = 1'b0, firstSeen = 1'b0;
  logic [23:0] firstRd = '0;
  logic [31:0] got [0:255];
  logic [31:0] expW [0:255];

  // monitor: sink handshake, read strobes, watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      sinkReady = randReady ? (($urandom % 4) != 0) : 1'b1;
      if (sinkValid && sinkReady && gotN < 256) begin
        got[gotN] = sinkData;
        gotN++;
      end
      if (memRdEn) begin
        rdCount++;
        if (!firstSeen) begin firstSeen = 1'b1; firstRd = memRdAddr; end
      end
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic clearRun();
    gotN = 0; rdCount = 0; firstSeen = 1'b0;
  endtask

  task automatic putDesc(input logic [23:0] at, input int n, input logic [23:0] nxt);
    mem[at[13:2]] = {8'(n), nxt};
    for (int i = 0; i < n; i++) mem[(at[13:2] + 12'(1 + i))] = $urandom;
  endtask

  // expected stream and cycle cost from the header rules
  task automatic expWalk(input logic [23:0] s);
    logic [23:0] a;
    logic [31:0] h;
    int n;
    expN = 0; expCost = 0; expErr = 1'b0;
    a = s;
    for (int d = 0; d < 64; d++) begin
      if ({1'b0, a & 24'hFFFFFC} + 25'd4 > 25'd8388608) begin expErr = 1'b1; break; end
      h = mem[a[13:2]];
      n = int'(h[31:24]);
      expCost += 11 + ((n > 0) ? 5 + 2 * n : 0);
      for (int i = 0; i < n; i++) begin
        expW[expN] = mem[(((a & 24'hFFFFFC) + 24'(4 + 4 * i)) >> 2) & 24'hFFF];
        expN++;
      end
      if (h[23:0] == TERM) break;
      a = h[23:0];
    end
  endtask

  task automatic startPulse(input logic [23:0] a);
    startAddr = a; startWr = 1'b1;
    tick(1);
    startWr = 1'b0;
  endtask

  task automatic waitEnd(output int n);
    n = 1;
    while (!doneIrq && !busErr && n < 20000) begin tick(1); n++; end
  endtask

  task automatic cmpStream(input string req);
    int bad = -1;
    for (int i = 0; i < expN && i < gotN; i++) if (got[i] !== expW[i] && bad < 0) bad = i;
    chk(gotN == expN, req, "word count", gotN, expN);
    chk(bad < 0, req, "word order/value",
        (bad < 0) ? 0 : longint'(got[bad]), (bad < 0) ? 0 : longint'(expW[bad]));
  endtask

  int n, k;
  logic [3:0] slot [0:11];

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    tick(3);
    // R1 reset state
    chk(!busy && !doneIrq && !busErr, "R1", "flags", {busy, doneIrq, busErr}, 0);
    chk(!memRdEn && !sinkValid, "R1", "strobes", {memRdEn, sinkValid}, 0);
    chk(baseAddr == 24'h0, "R1", "base", baseAddr, 0);
    rstN = 1'b1;
    tick(2);

    // R6 R3 R5: timing with sink always ready
    putDesc(24'h100, 2, 24'h200);
    putDesc(24'h200, 0, 24'h300);
    putDesc(24'h300, 3, TERM);
    expWalk(24'h100);
    clearRun();
    startPulse(24'h100);
    chk(busy && baseAddr == 24'h100, "R2", "start loads base", baseAddr, 24'h100);
    waitEnd(n);
    chk(doneIrq && n == expCost + 2, "R6", "done cycle", n, expCost + 2);
    chk(baseAddr == TERM && !busy, "R5", "terminal base", baseAddr, TERM);
    cmpStream("R3");
    tick(1);
    chk(!doneIrq, "R5", "done is one cycle", doneIrq, 0);

    // R4: unaligned start and next pointer
    putDesc(24'h400, 1, 24'h501);
    putDesc(24'h500, 2, TERM);
    expWalk(24'h402);
    clearRun();
    startPulse(24'h402);
    waitEnd(n);
    chk(firstRd == 24'h400, "R4", "first read aligned", firstRd, 24'h400);
    cmpStream("R4");

    // R2: start while busy ignored
    putDesc(24'h600, 2, 24'h700);
    putDesc(24'h700, 1, TERM);
    putDesc(24'h800, 4, TERM);
    expWalk(24'h600);
    clearRun();
    startPulse(24'h600);
    tick(4);
    startPulse(24'h800);
    chk(baseAddr == 24'h600, "R2", "base after ignored start", baseAddr, 24'h600);
    waitEnd(n);
    chk(doneIrq, "R2", "chain completes", doneIrq, 1);
    cmpStream("R2");

    // R7 R9: budget yield and hold-off
    budget = 16'd20;
    putDesc(24'h100, 3, 24'h200);
    putDesc(24'h200, 0, 24'h300);
    putDesc(24'h300, 1, TERM);
    expWalk(24'h100);
    clearRun();
    startPulse(24'h100);
    k = 0;
    while (baseAddr == 24'h100 && k < 500) begin tick(1); k++; end
    chk(baseAddr == 24'h200 && busy, "R7", "yield base", baseAddr, 24'h200);
    chk(gotN == 3, "R7", "descriptor finished before yield", gotN, 3);
    k = 0;
    while (!memRdEn && k < 500) begin tick(1); k++; end
    chk(k == HOLD + 1, "R9", "hold-off length", k, HOLD + 1);
    waitEnd(n);
    chk(doneIrq, "R7", "resumed walk completes", doneIrq, 1);
    cmpStream("R7");
    budget = 16'd1000;

    // R8: request low parks; resume on request
    putDesc(24'h100, 2, 24'h200);
    putDesc(24'h200, 2, 24'h300);
    putDesc(24'h300, 2, TERM);
    expWalk(24'h100);
    clearRun();
    devReq = 1'b0;
    startPulse(24'h100);
    tick(20);
    chk(busy && rdCount == 0 && gotN == 0, "R8", "parked before request", rdCount, 0);
    devReq = 1'b1;
    k = 0;
    while (!sinkValid && k < 200) begin tick(1); k++; end
    devReq = 1'b0;
    tick(60);
    chk(baseAddr == 24'h200 && busy, "R8", "parked base", baseAddr, 24'h200);
    chk(gotN == 2, "R8", "words before park", gotN, 2);
    devReq = 1'b1;
    waitEnd(n);
    chk(doneIrq, "R8", "resume completes", doneIrq, 1);
    cmpStream("R8");

    // R10: bus error on next pointer past memory
    putDesc(24'h100, 1, 24'h800000);
    clearRun();
    startPulse(24'h100);
    waitEnd(n);
    chk(busErr && !doneIrq && !busy, "R10", "error pulse", {busErr, doneIrq, busy}, 3'b100);
    chk(baseAddr == 24'h800000, "R10", "error base", baseAddr, 24'h800000);
    chk(gotN == 1, "R10", "words before error", gotN, 1);
    tick(1);
    chk(!busErr, "R10", "error is one cycle", busErr, 0);
    // start at terminator value: immediate error, no read
    clearRun();
    startPulse(TERM);
    waitEnd(n);
    chk(busErr && rdCount == 0, "R10", "no read on fault", rdCount, 0);
    chk(!busy, "R11", "idle after error", busy, 0);
    // last legal header address
    putDesc(24'h100, 0, 24'h7FFFFC);
    mem[4095] = {8'd0, TERM};
    clearRun();
    startPulse(24'h100);
    waitEnd(n);
    chk(doneIrq && !busErr, "R10", "boundary header legal", {doneIrq, busErr}, 2'b10);

    // random chains with back-pressure and random budgets
    randReady = 1'b1;
    for (int it = 0; it < 20; it++) begin
      int nd;
      for (int i = 0; i < 12; i++) slot[i] = 4'(i + 1);
      for (int i = 11; i > 0; i--) begin
        int j = int'($urandom % (i + 1));
        logic [3:0] t = slot[i]; slot[i] = slot[j]; slot[j] = t;
      end
      nd = 1 + int'($urandom % 5);
      for (int d = 0; d < nd; d++)
        putDesc({12'h0, slot[d], 8'h00}, int'($urandom % 7),
                (d == nd - 1) ? TERM : {12'h0, slot[d + 1], 8'h00});
      budget = 16'(15 + ($urandom % 200));
      expWalk({12'h0, slot[0], 8'h00});
      clearRun();
      startPulse({12'h0, slot[0], 8'h00});
      waitEnd(n);
      chk(doneIrq && baseAddr == TERM, "R5", "random done", baseAddr, TERM);
      cmpStream("R3");
      tick(1);
      chk(!busy, "R11", "random idle after done", busy, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule